// File: doc/BRIEF.md
# Streaming Twiddle Rotator for a Radix-2-Squared Pipeline Stage

This block sits between the second butterfly and the next stage of a single-path delay-feedback FFT pipeline. It takes one complex sample per clock, together with a valid flag and the stage's shared control counter. It multiplies the sample by a twiddle factor c + js looked up in a fixed-point table. It returns the rotated sample six clock edges later, along with the delayed flag and counter.

The table index comes from the counter value, so the twiddles stay in step with the butterflies without any extra control. The two most significant counter bits pick a weight, and that weight times the remaining low bits gives the exponent of the N-th root of unity. The table is computed when the design elaborates. The product uses four real multiplies, one subtraction and one addition. It is then rounded and clamped back to the sample width.

Top module: `twm_rotator`

## Requirements
- R1: `out_valid` and `out_cnt` reproduce `in_valid` and `in_cnt` from exactly six rising clock edges earlier. The rotated sample for an accepted input appears in that same cycle.
- R2: The table index k is weight(`in_cnt[7:6]`) × `in_cnt[5:0]`, with weights 0→0, 1→2, 2→1, 3→3. The twiddle is c = round(16384·cos(2πk/256)) and s = round(−16384·sin(2πk/256)), rounding halves upward.
- R3: For an input zr + j·zi, `out_re` = round((zr·c − zi·s)/16384) and `out_im` = round((zr·s + zi·c)/16384). Rounding is to nearest, with ties toward positive infinity, and the result is within 1 LSB of that reference.
- R4: A rounded result above 32767 is output as 32767, and a result below −32768 is output as −32768.
- R5: When the index is 0 (upper digit 0 or low bits 0), the twiddle is exactly 1. The output then equals the input bit for bit.
- R6: A new sample is accepted on every clock with `in_valid` high, back to back, with no stall.
- R7: While `out_valid` is low, `out_re` and `out_im` keep their previous values.
- R8: While `rst_n` is low, `out_valid`, `out_re`, `out_im` and `out_cnt` are all 0.
- R9: A sample presented with `in_valid` low is not rotated and does not disturb the samples around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| in_cnt | input | 8 | Shared stage counter value for this sample |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | 16 | Rotated real part |
| out_im | output | 16 | Rotated imaginary part |
| out_cnt | output | 8 | Counter value delayed with the sample |

## Verification
Each internal fault shows up at the ports after a fixed delay:
- A wrong index weight or a wrong table entry gives a wrong rotated value exactly six cycles after the affected counter value. A sweep of all 256 counter values therefore exposes any single bad entry.
- A missing or extra register in the data path or the flag path misaligns `out_valid`, `out_cnt` and the data against the input history. This is caught on the first sample after reset.
- A rounding or clamping fault appears only on inputs whose products land on a rounding tie or beyond full scale. Directed samples at 45 degrees with full-scale operands cover that case.
- A missing clock enable shows up as output data changing during an invalid gap.

// File: rtl/twm_pkg.sv
package twm_pkg;

  // Weight applied to the upper counter digit when forming the twiddle exponent
  function automatic logic [1:0] digit_weight(input logic [1:0] digit);
    logic [1:0] w;
    case (digit)
      2'd0:    w = 2'd0;
      2'd1:    w = 2'd2;
      2'd2:    w = 2'd1;
      default: w = 2'd3;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/twm_index.sv
module twm_index #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] idx_o
);
  import twm_pkg::*;

  localparam int LOW_W = CNT_W - 2;

  logic [1:0]       weight;
  logic [CNT_W-1:0] weight_ext;
  logic [CNT_W-1:0] low_ext;

  always_comb begin
    weight     = digit_weight(cnt_i[CNT_W-1 -: 2]);
    weight_ext = {{LOW_W{1'b0}}, weight};
    low_ext    = {2'b00, cnt_i[LOW_W-1:0]};
    idx_o      = weight_ext * low_ext;
  end

endmodule

// File: rtl/twm_rom.sv
module twm_rom #(
  parameter int CNT_W = 8,
  parameter int TW_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [CNT_W-1:0]       idx_i,
  output logic signed [TW_W-1:0] c_o,
  output logic signed [TW_W-1:0] s_o
);

  localparam int  DEPTH  = 1 << CNT_W;
  localparam int  FRAC   = TW_W - 2;
  localparam real UNITY  = real'(1 << FRAC);
  localparam real TWO_PI = 6.283185307179586;
  localparam logic signed [TW_W-1:0] ONE = TW_W'(1 << FRAC);

  logic signed [TW_W-1:0] tab_c [DEPTH];
  logic signed [TW_W-1:0] tab_s [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam real ANG = TWO_PI * real'(k) / real'(DEPTH);
    localparam int  CV  = $rtoi($floor(UNITY * $cos(ANG) + 0.5));
    localparam int  SV  = $rtoi($floor(-UNITY * $sin(ANG) + 0.5));
    assign tab_c[k] = TW_W'(CV);
    assign tab_s[k] = TW_W'(SV);
  end

  logic signed [TW_W-1:0] c_d, s_d;

  always_comb begin
    c_d = c_o;
    s_d = s_o;
    if (en_i) begin
      c_d = tab_c[idx_i];
      s_d = tab_s[idx_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_o <= '0;
      s_o <= '0;
    end else begin
      c_o <= c_d;
      s_o <= s_d;
    end
  end

  // R5: a zero exponent must read back as exactly unity
  assert_unity_twiddle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && idx_i == '0) |=> (c_o == ONE && s_o == '0));

endmodule

// File: rtl/twm_cmul.sv
module twm_cmul #(
  parameter int DATA_W = 16,
  parameter int TW_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               en_i,
  input  logic signed [DATA_W-1:0] zr_i,
  input  logic signed [DATA_W-1:0] zi_i,
  input  logic signed [TW_W-1:0]   c_i,
  input  logic signed [TW_W-1:0]   s_i,
  output logic signed [DATA_W-1:0] re_o,
  output logic signed [DATA_W-1:0] im_o
);

  localparam int PW   = DATA_W + TW_W;
  localparam int SW   = PW + 1;
  localparam int FRAC = TW_W - 2;
  localparam int RW   = SW - FRAC;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [RW-1:0] RMAX = RW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [RW-1:0] RMIN = -RMAX - RW'(1);
  localparam logic signed [DATA_W-1:0] DMAX = DATA_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [DATA_W-1:0] DMIN = -DMAX - DATA_W'(1);

  // stage 3: four real products
  logic signed [PW-1:0] p_rc_q, p_is_q, p_rs_q, p_ic_q;
  logic signed [PW-1:0] p_rc_d, p_is_d, p_rs_d, p_ic_d;
  // stage 4: difference and sum
  logic signed [SW-1:0] sum_re_q, sum_im_q, sum_re_d, sum_im_d;
  // stage 5: rounded
  logic signed [SW-1:0] biased_re, biased_im;
  logic signed [RW-1:0] rnd_re_q, rnd_im_q, rnd_re_d, rnd_im_d;
  // stage 6: clamped
  logic signed [DATA_W-1:0] re_d, im_d;

  function automatic logic signed [DATA_W-1:0] clamp(input logic signed [RW-1:0] v);
    logic signed [DATA_W-1:0] r;
    if (v > RMAX)      r = DMAX;
    else if (v < RMIN) r = DMIN;
    else               r = v[DATA_W-1:0];
    return r;
  endfunction

  always_comb begin
    p_rc_d = p_rc_q;
    p_is_d = p_is_q;
    p_rs_d = p_rs_q;
    p_ic_d = p_ic_q;
    if (en_i[0]) begin
      p_rc_d = PW'(zr_i) * PW'(c_i);
      p_is_d = PW'(zi_i) * PW'(s_i);
      p_rs_d = PW'(zr_i) * PW'(s_i);
      p_ic_d = PW'(zi_i) * PW'(c_i);
    end

    sum_re_d = sum_re_q;
    sum_im_d = sum_im_q;
    if (en_i[1]) begin
      sum_re_d = SW'(p_rc_q) - SW'(p_is_q);
      sum_im_d = SW'(p_rs_q) + SW'(p_ic_q);
    end

    biased_re = sum_re_q + HALF;
    biased_im = sum_im_q + HALF;
    rnd_re_d  = rnd_re_q;
    rnd_im_d  = rnd_im_q;
    if (en_i[2]) begin
      rnd_re_d = biased_re[SW-1:FRAC];
      rnd_im_d = biased_im[SW-1:FRAC];
    end

    re_d = re_o;
    im_d = im_o;
    if (en_i[3]) begin
      re_d = clamp(rnd_re_q);
      im_d = clamp(rnd_im_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rc_q   <= '0;
      p_is_q   <= '0;
      p_rs_q   <= '0;
      p_ic_q   <= '0;
      sum_re_q <= '0;
      sum_im_q <= '0;
      rnd_re_q <= '0;
      rnd_im_q <= '0;
      re_o     <= '0;
      im_o     <= '0;
    end else begin
      p_rc_q   <= p_rc_d;
      p_is_q   <= p_is_d;
      p_rs_q   <= p_rs_d;
      p_ic_q   <= p_ic_d;
      sum_re_q <= sum_re_d;
      sum_im_q <= sum_im_d;
      rnd_re_q <= rnd_re_d;
      rnd_im_q <= rnd_im_d;
      re_o     <= re_d;
      im_o     <= im_d;
    end
  end

  // R4: overflowing rounded values clamp to the rails
  assert_clamp_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[3] && rnd_re_q > RMAX) |=> (re_o == DMAX));
  assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[3] && rnd_im_q < RMIN) |=> (im_o == DMIN));
  // R7: no output update without a valid sample in the last stage
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[3] |=> ($stable(re_o) && $stable(im_o)));

endmodule

// File: rtl/twm_rotator.sv
module twm_rotator #(
  parameter int DATA_W = 16,
  parameter int TW_W   = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic [CNT_W-1:0]  out_cnt
);

  localparam int LAT = 6;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  // valid and counter delay line
  logic             vld_q [LAT];
  logic             vld_d [LAT];
  logic [CNT_W-1:0] cnt_q [LAT];
  logic [CNT_W-1:0] cnt_d [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_dly
    if (i == 0) begin : g_head
      always_comb begin
        vld_d[i] = in_valid;
        cnt_d[i] = in_cnt;
      end
    end else begin : g_body
      always_comb begin
        vld_d[i] = vld_q[i-1];
        cnt_d[i] = cnt_q[i-1];
      end
    end
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
        vld_q[i] <= 1'b0;
        cnt_q[i] <= '0;
      end else begin
        vld_q[i] <= vld_d[i];
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

  // stage 1: capture sample and compute exponent; stage 2: align with table read
  logic [CNT_W-1:0]         idx_comb, idx_q, idx_d;
  logic signed [DATA_W-1:0] zr1_q, zi1_q, zr1_d, zi1_d;
  logic signed [DATA_W-1:0] zr2_q, zi2_q, zr2_d, zi2_d;

  twm_index #(.CNT_W(CNT_W)) u_index (
    .cnt_i (in_cnt),
    .idx_o (idx_comb)
  );

  always_comb begin
    idx_d = idx_q;
    zr1_d = zr1_q;
    zi1_d = zi1_q;
    if (in_valid) begin
      idx_d = idx_comb;
      zr1_d = in_re;
      zi1_d = in_im;
    end
    zr2_d = zr2_q;
    zi2_d = zi2_q;
    if (vld_q[0]) begin
      zr2_d = zr1_q;
      zi2_d = zi1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      idx_q <= '0;
      zr1_q <= '0;
      zi1_q <= '0;
      zr2_q <= '0;
      zi2_q <= '0;
    end else begin
      idx_q <= idx_d;
      zr1_q <= zr1_d;
      zi1_q <= zi1_d;
      zr2_q <= zr2_d;
      zi2_q <= zi2_d;
    end
  end

  logic signed [TW_W-1:0] tw_c, tw_s;

  twm_rom #(.CNT_W(CNT_W), .TW_W(TW_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en_i  (vld_q[0]),
    .idx_i (idx_q),
    .c_o   (tw_c),
    .s_o   (tw_s)
  );

  logic signed [DATA_W-1:0] rot_re, rot_im;

  twm_cmul #(.DATA_W(DATA_W), .TW_W(TW_W)) u_cmul (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en_i  ({vld_q[4], vld_q[3], vld_q[2], vld_q[1]}),
    .zr_i  (zr2_q),
    .zi_i  (zi2_q),
    .c_i   (tw_c),
    .s_i   (tw_s),
    .re_o  (rot_re),
    .im_o  (rot_im)
  );

  assign out_valid = vld_q[LAT-1];
  assign out_cnt   = cnt_q[LAT-1];
  assign out_re    = rot_re;
  assign out_im    = rot_im;

  // cycles since reset release, so the latency checks never look before it
  logic [3:0] since_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)             since_q <= '0;
    else if (since_q != 4'hF) since_q <= since_q + 4'd1;
  end

  // R1: fixed six-edge alignment of flag and counter
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (since_q > 4'd7) |-> (out_valid == $past(in_valid, 6)));
  assert_cnt_latency_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (since_q > 4'd7) |-> (out_cnt == $past(in_cnt, 6)));

endmodule

// File: tb/twm_rotator_bench.sv
module twm_rotator_bench;

  localparam int HMAX = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic [7:0]  in_cnt = '0;
  logic        out_valid;
  logic [15:0] out_re, out_im;
  logic [7:0]  out_cnt;

  always #2.5 clk = ~clk;

  twm_rotator u_twm_rotator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_cnt(in_cnt), .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_cnt(out_cnt)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 0;
  logic  hv   [HMAX];
  int    hre  [HMAX];
  int    him  [HMAX];
  int    hcnt [HMAX];
  int    htol [HMAX];
  string htag [HMAX];
  int    prev_re = 0, prev_im = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // weights for the upper counter digit, as listed in R2
  function automatic int weight(input int d);
    case (d)
      0: return 0;
      1: return 2;
      2: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // reference rotation from R2 and R3
  task automatic reference(input int zr, input int zi, input int cnt,
                           output int er, output int ei);
    int     k;
    longint c, s, sr, si;
    real    a;
    k  = weight(cnt / 64) * (cnt % 64);
    a  = 6.283185307179586 * real'(k) / 256.0;
    c  = longint'($rtoi($floor(16384.0 * $cos(a) + 0.5)));
    s  = longint'($rtoi($floor(-16384.0 * $sin(a) + 0.5)));
    sr = longint'(zr) * c - longint'(zi) * s;
    si = longint'(zr) * s + longint'(zi) * c;
    er = clamp16((sr + 8192) >>> 14);
    ei = clamp16((si + 8192) >>> 14);
  endtask

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // one clock: check the output due now, then drive the next input
  task automatic send(input int zr, input int zi, input int cnt, input bit v,
                      input int tol, input string tag);
    int er, ei, j;
    @(negedge clk);
    j = cyc - 6;
    if (j >= 0 && hv[j]) begin
      check(out_valid === 1'b1, "R1", "out_valid high", int'(out_valid), 1);
      check(int'(out_cnt) == hcnt[j], "R1", "out_cnt", int'(out_cnt), hcnt[j]);
      check(absi(sx(out_re) - hre[j]) <= htol[j], htag[j], "out_re", sx(out_re), hre[j]);
      check(absi(sx(out_im) - him[j]) <= htol[j], htag[j], "out_im", sx(out_im), him[j]);
    end else begin
      check(out_valid === 1'b0, "R1", "out_valid low", int'(out_valid), 0);
      check(sx(out_re) == prev_re && sx(out_im) == prev_im, "R7", "held re",
            sx(out_re), prev_re);
    end
    prev_re = sx(out_re);
    prev_im = sx(out_im);
    in_valid = v;
    in_re    = 16'(zr);
    in_im    = 16'(zi);
    in_cnt   = 8'(cnt);
    reference(zr, zi, cnt, er, ei);
    hv[cyc]   = v;
    hre[cyc]  = er;
    him[cyc]  = ei;
    hcnt[cyc] = cnt;
    htol[cyc] = tol;
    htag[cyc] = tag;
    cyc++;
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(out_re === 16'd0 && out_im === 16'd0, "R8", "data in reset", sx(out_re), 0);
    check(out_cnt === 8'd0, "R8", "out_cnt in reset", int'(out_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R8", "out_valid after release", int'(out_valid), 0);
  endtask

  // R5: exponent 0 for upper digit 0 and for low bits 0, exact pass-through
  task automatic t_trivial();
    for (int i = 0; i < 64; i++) send(rnd16(), rnd16(), i, 1'b1, 0, "R5");
    send(-32768, 32767, 8'h40, 1'b1, 0, "R5");
    send(12345, -321, 8'h80, 1'b1, 0, "R5");
    send(-1, 1, 8'hC0, 1'b1, 0, "R5");
  endtask

  // R2, R3, R6: every counter value back to back
  task automatic t_sweep();
    for (int i = 0; i < 256; i++) send(rnd16(), rnd16(), i, 1'b1, 1, "R3");
    for (int i = 0; i < 8; i++) send(10000, 0, 8'h40 + i, 1'b1, 1, "R2");
  endtask

  // R4: full-scale operands at 45 degrees overflow both rails
  task automatic t_saturate();
    send(32767, 32767, 8'h50, 1'b1, 0, "R4");
    send(-32768, -32768, 8'h50, 1'b1, 0, "R4");
    send(32767, -32768, 8'h50, 1'b1, 0, "R4");
    send(-32768, 32767, 8'hD0, 1'b1, 1, "R4");
  endtask

  // R9, R7: invalid slots with noisy data between valid samples
  task automatic t_gaps();
    for (int i = 0; i < 20; i++) begin
      send(rnd16(), rnd16(), 8'hC0 + i, 1'b1, 1, "R9");
      send(rnd16(), rnd16(), rnd16() & 255, 1'b0, 1, "R9");
      if (i % 4 == 0) send(32767, 32767, 8'h55, 1'b0, 1, "R9");
    end
  endtask

  task automatic t_flush();
    for (int i = 0; i < 10; i++) send(0, 0, 0, 1'b0, 0, "R7");
  endtask

  initial begin
    for (int i = 0; i < HMAX; i++) hv[i] = 1'b0;
    t_reset();
    t_trivial();
    t_sweep();
    t_saturate();
    t_gaps();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule